// File: doc/BRIEF.md
# Storage Channel Interrupt Controller with Fault Address Capture

This block gathers the interrupt sources of a single storage channel and presents them to the host as one level-sensitive interrupt line. There are two sources. One is the attached device raising its interrupt. The other is the DMA engine reporting a memory error on the system bus. Each source sets a sticky pending bit. A separate enable mask decides which pending bits reach the interrupt line. Software reads and changes the state through a small word-addressed register port.

The first memory error after the error bit was last cleared stores the faulting bus address. Software can read that address later as two 32-bit words. There is also a clearing path that software does not write. Whenever the channel's device status byte is read and its busy flag shows the device idle, every pending bit is dropped. This lets ordinary polling of the status byte acknowledge the interrupt.

Top module: `chan_irq_ctrl`

## Requirements
- R1: After reset, the pending bits, the enable bits and the captured fault address are all zero, and `irq_o` is low.
- R2: A cycle with `dev_int` high sets pending bit 0. A cycle with `dma_mem_err` high sets pending bit 1. Both bits stay set until cleared. The pending bits read in bits 1:0 at byte address 0x0C, and the other read bits are zero.
- R3: A write to byte address 0x0C clears each pending bit whose write-data bit (1:0) is 1 and leaves the others. The next read shows the new value.
- R4: A write to byte address 0x14 sets each enable bit whose write-data bit (1:0) is 1. The enable bits read in bits 1:0 at 0x14.
- R5: A write to byte address 0x1C clears each enable bit whose write-data bit (1:0) is 1. The enable bits also read at 0x1C.
- R6: `irq_o` is high exactly when some pending bit and its enable bit are both 1. It reflects the register state in the cycle after the event that changed it.
- R7: A cycle with `stat_rd` high and `stat_byte` bit 7 low clears both pending bits. With bit 7 high, the read has no effect on them.
- R8: A source event in the same cycle as a clear of its bit, by register write or by status read, leaves the bit set.
- R9: A memory error stores `dma_fault_addr` only when pending bit 1 is clear, or is being cleared in the same cycle. Later errors leave the stored address unchanged. The low word reads at 0x00 and the high word at 0x04.
- R10: Writes to 0x00, 0x04 and unmapped addresses change no state. Reads of unmapped addresses return zero. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| dev_int | input | 1 | Device interrupt event |
| dma_mem_err | input | 1 | DMA memory error event |
| dma_fault_addr | input | ERR_W | Bus address of the failing access |
| stat_rd | input | 1 | Device status byte is being read |
| stat_byte | input | 8 | Value of the device status byte being read |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
Suppose a pending or enable bit is wrong, for example set from the wrong source or not cleared. The wrong value shows on `irq_o` and in the readback one cycle after the event. The bench therefore compares both against its model on every clock. A fault address that is wrongly overwritten or wrongly captured stays wrong until the next clear of the error bit. It shows on the very first read of 0x00 or 0x04 that follows, so the sequences read both words right after repeated errors and after clears that coincide with errors.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  localparam int NSRC       = 2;
  localparam int SRC_DEV    = 0;
  localparam int SRC_MEM    = 1;
  localparam int IDX_ERR_LO = 0;
  localparam int IDX_ERR_HI = 1;
  localparam int IDX_PEND   = 3;
  localparam int IDX_EN_SET = 5;
  localparam int IDX_EN_CLR = 7;

  // Sticky bit update: a fresh event wins over a clear in the same cycle.
  function automatic logic [NSRC-1:0] sticky_next(logic [NSRC-1:0] cur,
                                                  logic [NSRC-1:0] set,
                                                  logic [NSRC-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [31:0] widen(logic [NSRC-1:0] v);
    return {{(32-NSRC){1'b0}}, v};
  endfunction
endpackage

// File: rtl/chan_irq_pend.sv
module chan_irq_pend
  import chan_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] en_set_i,
  input  logic [NSRC-1:0] en_clr_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] en_o
);
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] en_d;

  assign pend_d = sticky_next(pend_o, set_i, clr_i);
  assign en_d   = sticky_next(en_o, en_set_i, en_clr_i);

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_o[i] <= 1'b0;
        en_o[i]   <= 1'b0;
      end else begin
        pend_o[i] <= pend_d[i];
        en_o[i]   <= en_d[i];
      end
    end
  end
endmodule

// File: rtl/chan_irq_errcap.sv
module chan_irq_errcap #(
  parameter int ERR_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [ERR_W-1:0] addr_i,
  output logic [ERR_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     addr_o <= '0;
    else if (cap_i) addr_o <= addr_i;
  end
endmodule

// File: rtl/chan_irq_ctrl.sv
module chan_irq_ctrl
  import chan_irq_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int ERR_W    = 64,
  parameter int BUSY_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              dev_int,
  input  logic              dma_mem_err,
  input  logic [ERR_W-1:0]  dma_fault_addr,
  input  logic              stat_rd,
  input  logic [7:0]        stat_byte,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [NSRC-1:0]  wbits;
  logic             wr_pend, wr_en_set, wr_en_clr, auto_clr, cap_ev;
  logic [NSRC-1:0]  clr_vec, set_vec, en_set_vec, en_clr_vec;
  logic [NSRC-1:0]  pend_q, en_q;
  logic [ERR_W-1:0] err_q;
  logic             unused_bits;

  assign idx         = bus_addr[ADDR_W-1:2];
  assign wbits       = bus_wdata[NSRC-1:0];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:NSRC], stat_byte};

  assign wr_pend   = bus_wr && (idx == IDX_W'(IDX_PEND));
  assign wr_en_set = bus_wr && (idx == IDX_W'(IDX_EN_SET));
  assign wr_en_clr = bus_wr && (idx == IDX_W'(IDX_EN_CLR));
  assign auto_clr  = stat_rd && !stat_byte[BUSY_BIT];

  assign clr_vec    = auto_clr ? '1 : (wr_pend ? wbits : '0);
  assign set_vec    = {dma_mem_err, dev_int};
  assign en_set_vec = wr_en_set ? wbits : '0;
  assign en_clr_vec = wr_en_clr ? wbits : '0;
  assign cap_ev     = dma_mem_err && (!pend_q[SRC_MEM] || clr_vec[SRC_MEM]);

  chan_irq_pend u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .en_set_i (en_set_vec),
    .en_clr_i (en_clr_vec),
    .pend_o   (pend_q),
    .en_o     (en_q)
  );

  chan_irq_errcap #(.ERR_W(ERR_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (cap_ev),
    .addr_i (dma_fault_addr),
    .addr_o (err_q)
  );

  assign irq_o = |(pend_q & en_q);

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IDX_W'(IDX_ERR_LO): bus_rdata = err_q[31:0];
      IDX_W'(IDX_ERR_HI): bus_rdata = 32'(err_q >> 32);
      IDX_W'(IDX_PEND):   bus_rdata = widen(pend_q);
      IDX_W'(IDX_EN_SET),
      IDX_W'(IDX_EN_CLR): bus_rdata = widen(en_q);
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/chan_irq_ctrl_chk.sv
module chan_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] wbits,
  input logic       dev_int,
  input logic       dma_mem_err,
  input logic       stat_rd,
  input logic       stat_busy,
  input logic       irq_o,
  input logic [1:0] pend_q,
  input logic [1:0] en_q,
  input logic [63:0] err_q,
  input logic       wr_pend,
  input logic       wr_en_set,
  input logic       wr_en_clr,
  input logic       cap_ev
);
  AST_DEV_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    dev_int |=> pend_q[0]); // R2
  AST_MEM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mem_err |=> pend_q[1]); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && wbits[0] && !dev_int) |=> !pend_q[0]); // R3
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_set && wbits[1]) |=> en_q[1]); // R4
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_clr && wbits[0]) |=> !en_q[0]); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 2'b00) |-> !irq_o); // R6
  AST_AUTO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !stat_busy && !dev_int && !dma_mem_err) |=> (pend_q == 2'b00)); // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ev |=> $stable(err_q)); // R9
endmodule

bind chan_irq_ctrl chan_irq_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wbits       (bus_wdata[1:0]),
  .dev_int     (dev_int),
  .dma_mem_err (dma_mem_err),
  .stat_rd     (stat_rd),
  .stat_busy   (stat_byte[BUSY_BIT]),
  .irq_o       (irq_o),
  .pend_q      (pend_q),
  .en_q        (en_q),
  .err_q       (64'(err_q)),
  .wr_pend     (wr_pend),
  .wr_en_set   (wr_en_set),
  .wr_en_clr   (wr_en_clr),
  .cap_ev      (cap_ev)
);

// File: tb/sim_chan_irq_ctrl.sv
module sim_chan_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = 5'h0C;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dev_int = 1'b0;
  logic        dma_mem_err = 1'b0;
  logic [63:0] dma_fault_addr = '0;
  logic        stat_rd = 1'b0;
  logic [7:0]  stat_byte = '0;
  logic        irq_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // behavioural reference state
  int          m_pend = 0;
  int          m_en = 0;
  logic [63:0] m_err = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_int(dev_int),
    .dma_mem_err(dma_mem_err), .dma_fault_addr(dma_fault_addr),
    .stat_rd(stat_rd), .stat_byte(stat_byte), .irq_o(irq_o)
  );

  function automatic logic [31:0] model_read(logic [4:0] a);
    case (a >> 2)
      0: return m_err[31:0];
      1: return m_err[63:32];
      3: return 32'(m_pend);
      5, 7: return 32'(m_en);
      default: return 32'h0;
    endcase
  endfunction

  // compare now, then advance the model by one clock using the driven inputs
  task automatic step(string tag);
    logic [31:0] exp_rd;
    logic        exp_irq;
    int          clrm, setm, wd;
    #1;
    exp_rd  = model_read(bus_addr);
    exp_irq = (m_pend & m_en) != 0;
    n_checks++;
    if (bus_rdata !== exp_rd) begin
      n_fail++;
      $display("FAIL %s rdata@%h act=%h exp=%h", tag, bus_addr, bus_rdata, exp_rd);
    end
    n_checks++;
    if (irq_o !== exp_irq) begin
      n_fail++;
      $display("FAIL %s irq_o act=%b exp=%b", tag, irq_o, exp_irq);
    end
    wd = int'(bus_wdata[1:0]);
    clrm = 0;
    if (rst_n && bus_wr && (bus_addr >> 2) == 3) clrm = wd;
    if (rst_n && stat_rd && !stat_byte[7]) clrm = 3;
    setm = (dma_mem_err ? 2 : 0) + (dev_int ? 1 : 0);
    if (rst_n) begin
      if (dma_mem_err && (((m_pend & 2) == 0) || ((clrm & 2) != 0))) m_err = dma_fault_addr;
      m_pend = (m_pend & ~clrm) | setm;
      if (bus_wr && (bus_addr >> 2) == 5) m_en = m_en | wd;
      if (bus_wr && (bus_addr >> 2) == 7) m_en = m_en & ~wd;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr = 0; dev_int = 0; dma_mem_err = 0; stat_rd = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, string tag);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    step(tag);
    idle();
  endtask

  task automatic rd(logic [4:0] a, string tag);
    bus_addr = a;
    step(tag);
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state visible at every register
    rd(5'h00, "R1"); rd(5'h04, "R1"); rd(5'h0C, "R1"); rd(5'h14, "R1");
    rst_n = 1'b1;
    rd(5'h1C, "R1"); rd(5'h0C, "R1");

    // R2: device event latches, no irq while disabled
    dev_int = 1; rd(5'h0C, "R2"); idle();
    rd(5'h0C, "R2"); rd(5'h0E, "R10");
    // R4/R6: enable both sources
    wr(5'h14, 32'h3, "R4"); rd(5'h14, "R4"); rd(5'h0C, "R6");
    // R3: write-one-to-clear bit 0
    wr(5'h0C, 32'hFFFF_FFFD, "R3"); rd(5'h0C, "R3");

    // R9: first error captures, second does not overwrite
    dma_mem_err = 1; dma_fault_addr = 64'h1234_5678_9ABC_DEF0; rd(5'h00, "R9"); idle();
    rd(5'h00, "R9"); rd(5'h04, "R9");
    dma_mem_err = 1; dma_fault_addr = 64'hFFFF_0000_1111_2222; rd(5'h0C, "R9"); idle();
    rd(5'h00, "R9"); rd(5'h04, "R9");
    // R10: writes to read-only and unmapped words
    wr(5'h00, 32'hDEAD_BEEF, "R10"); wr(5'h04, 32'h5555_AAAA, "R10");
    wr(5'h18, 32'h3, "R10"); rd(5'h00, "R10"); rd(5'h04, "R10"); rd(5'h14, "R10");
    rd(5'h08, "R10"); rd(5'h10, "R10");

    // R7: busy status read leaves pending, idle status read clears
    dev_int = 1; rd(5'h0C, "R7"); idle();
    stat_rd = 1; stat_byte = 8'h80; rd(5'h0C, "R7"); idle();
    rd(5'h0C, "R7");
    stat_rd = 1; stat_byte = 8'h7F; rd(5'h0C, "R7"); idle();
    rd(5'h0C, "R7");

    // R9: after clear, a new error captures again
    dma_mem_err = 1; dma_fault_addr = 64'h0000_00AB_CDEF_0123; rd(5'h00, "R9"); idle();
    rd(5'h00, "R9"); rd(5'h04, "R9");

    // R8: error coincident with its clear write keeps bit and captures anew
    dma_mem_err = 1; dma_fault_addr = 64'h7777_6666_5555_4444;
    wr(5'h0C, 32'h2, "R8"); rd(5'h0C, "R8"); rd(5'h00, "R8"); rd(5'h04, "R8");
    // R8: device event coincident with idle status read
    dev_int = 1; stat_rd = 1; stat_byte = 8'h00; rd(5'h0C, "R8"); idle();
    rd(5'h0C, "R8");

    // R5/R6: drop enable 0, only error source drives the line
    wr(5'h0C, 32'h3, "R3"); rd(5'h0C, "R3");
    wr(5'h1C, 32'h1, "R5"); rd(5'h1C, "R5");
    dev_int = 1; rd(5'h0C, "R6"); idle();
    rd(5'h0C, "R6");
    dma_mem_err = 1; dma_fault_addr = 64'h1; rd(5'h0C, "R6"); idle();
    rd(5'h0C, "R6");
    wr(5'h1C, 32'h2, "R5"); rd(5'h14, "R5"); rd(5'h0C, "R6");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule